// File: doc/BRIEF.md
# Four-Lane Integer Group with Shared Multiplier and Load Port

A processing group of four integer lanes that carry one instruction stream. Each lane owns a one-cycle adder/logic unit, while the group holds exactly one 16x16 multiplier and one load port that every lane must borrow. A fixed-priority arbiter (lane 0 highest) grants each shared unit to at most one lane per cycle; every other requester stalls with its instruction and operands frozen until its turn comes.

Lanes take instructions over a per-lane valid/ready handshake and return results on per-lane valid/data outputs. A launch pulse starts the group in one of two issue modes. In lockstep mode all lanes open together and the group advances as one: a stall in any lane blocks new instructions in every lane. In skewed mode lane k opens k cycles after lane 0, so a repeated add-add-add-multiply stream reaches the multiplier one lane per cycle and never collides.

Top module: `quad_lane_group`

## Requirements
- R1: Opcodes (3 bits): 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 pass operand A, 6 multiply, 7 load. ALU results are 16 bits wide (add and subtract wrap modulo 2^16), zero-extended to 32 bits. An ALU op accepted at clock edge n shows res_valid and its data after edge n+1.
- R2: Multiply is unsigned 16x16 to 32 bits; its result shows after the edge that closes the cycle in which the lane held the multiplier grant.
- R3: When several lanes hold a pending multiply, the lowest lane index wins; each losing lane asserts its lane_stall bit and keeps its operands unchanged until granted.
- R4: The load port serves one lane per cycle with the same priority rule; in the grant cycle mem_req is 1 and mem_addr carries the low 8 bits of the winner's operand A; mem_rdata is taken on the following cycle and returned, zero-extended, as that lane's result.
- R5: A stalled lane keeps in_ready low and shows no res_valid on the next cycle.
- R6: After a launch with skew_mode=1, in_ready opens as 0001, 0011, 0111, 1111 on consecutive cycles (idle lanes); with skew_mode=0 all four open on the first cycle.
- R7: In lockstep mode, while any lane stalls, no lane accepts an instruction.
- R8: In skewed mode a stream of repeated add, add, add, multiply on all four lanes completes with no stall; four iterations span 19 result cycles.
- R9: For that same workload, lockstep mode takes more cycles for the same number of completions than skewed mode.
- R10: After reset and before the first launch, in_ready, res_valid, lane_stall and mem_req are all zero.
- R11: The multiplier and the load port are arbitrated independently: a multiply and a load in the same cycle both proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch | input | 1 | Start pulse; samples skew_mode and restarts the lane opening sequence |
| skew_mode | input | 1 | 1 = skewed issue, 0 = lockstep |
| in_valid | input | 4 | Per-lane instruction valid |
| in_op | input | 12 | Per-lane 3-bit opcode, lane k in bits 3k+2..3k |
| in_a | input | 64 | Per-lane operand A, lane k in bits 16k+15..16k |
| in_b | input | 64 | Per-lane operand B, same packing |
| in_ready | output | 4 | Per-lane instruction accepted this cycle when valid |
| lane_stall | output | 4 | Lane waits for a shared unit |
| res_valid | output | 4 | Per-lane result valid |
| res_data | output | 128 | Per-lane 32-bit result, lane k in bits 32k+31..32k |
| mem_req | output | 1 | Load request this cycle |
| mem_addr | output | 8 | Load address |
| mem_rdata | input | 16 | Load data, one cycle after mem_req |

## Verification
The bench builds the group with its defaults: four lanes, 16-bit operands and an 8-bit load address. Four lanes make a full priority cascade reachable, where three lanes stall by one, two and three cycles behind lane 0, and let a three-adds-then-multiply stream fill every skew slot exactly. The 16-bit width puts subtract wrap-around and the largest product 0xFFFF*0xFFFF within reach, and the 8-bit address lets the bench compute every load value from a closed formula.

// File: rtl/qlg_pkg.sv
package qlg_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_PASS = 3'd5,
        OP_MUL  = 3'd6,
        OP_LOAD = 3'd7
    } op_e;

endpackage

// File: rtl/qlg_prio_arb.sv
module qlg_prio_arb #(
    parameter int N = 4
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            gnt[i] = req[i] && !taken;
            taken  = taken || req[i];
        end
    end

endmodule

// File: rtl/qlg_stagger.sv
module qlg_stagger #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic                 skew_mode,
    output logic [NUM_LANES-1:0] lane_en,
    output logic                 skew_q
);

    localparam int CNT_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NUM_LANES - 1);

    typedef struct packed {
        logic             active;
        logic             skew;
        logic [CNT_W-1:0] cnt;
    } stag_state_t;

    stag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (launch) begin
            st_d.active = 1'b1;
            st_d.skew   = skew_mode;
            st_d.cnt    = '0;
        end else if (st_q.active && st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign skew_q = st_q.skew;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_en
        if (k == 0) begin : g_first
            assign lane_en[k] = st_q.active;
        end else begin : g_rest
            assign lane_en[k] = st_q.active && (!st_q.skew || st_q.cnt >= CNT_W'(k));
        end
    end

endmodule

// File: rtl/qlg_lane.sv
module qlg_lane
    import qlg_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int RES_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    input  logic              enable,
    input  logic              group_hold,
    input  logic              mul_gnt,
    input  logic              mem_gnt,
    input  logic [RES_W-1:0]  mul_prod,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              in_ready,
    output logic              mul_req,
    output logic              mem_req,
    output logic              stall,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data,
    output logic [DATA_W-1:0] slot_a,
    output logic [DATA_W-1:0] slot_b
);

    typedef struct packed {
        logic              slot_v;
        op_e               slot_op;
        logic [DATA_W-1:0] slot_a;
        logic [DATA_W-1:0] slot_b;
        logic              res_v;
        logic              res_load;
        logic [RES_W-1:0]  res_val;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic        done;

    function automatic logic [DATA_W-1:0] alu_fn(input op_e op,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            default: return a;
        endcase
    endfunction

    assign mul_req  = st_q.slot_v && st_q.slot_op == OP_MUL;
    assign mem_req  = st_q.slot_v && st_q.slot_op == OP_LOAD;
    assign stall    = (mul_req && !mul_gnt) || (mem_req && !mem_gnt);
    assign done     = st_q.slot_v && !stall;
    assign in_ready = enable && !stall && !group_hold;

    always_comb begin
        st_d       = st_q;
        st_d.res_v = done;
        if (done) begin
            st_d.res_load = (st_q.slot_op == OP_LOAD);
            if (st_q.slot_op == OP_MUL) st_d.res_val = mul_prod;
            else                        st_d.res_val = RES_W'(alu_fn(st_q.slot_op, st_q.slot_a, st_q.slot_b));
        end
        if (in_valid && in_ready) begin
            st_d.slot_v  = 1'b1;
            st_d.slot_op = op_e'(in_op);
            st_d.slot_a  = in_a;
            st_d.slot_b  = in_b;
        end else if (done) begin
            st_d.slot_v = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.res_v;
    assign res_data  = st_q.res_load ? RES_W'(mem_rdata) : st_q.res_val;
    assign slot_a    = st_q.slot_a;
    assign slot_b    = st_q.slot_b;

endmodule

// File: rtl/quad_lane_group.sv
module quad_lane_group
    import qlg_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          launch,
    input  logic                          skew_mode,
    input  logic [NUM_LANES-1:0]          in_valid,
    input  logic [NUM_LANES*OP_W-1:0]     in_op,
    input  logic [NUM_LANES*DATA_W-1:0]   in_a,
    input  logic [NUM_LANES*DATA_W-1:0]   in_b,
    output logic [NUM_LANES-1:0]          in_ready,
    output logic [NUM_LANES-1:0]          lane_stall,
    output logic [NUM_LANES-1:0]          res_valid,
    output logic [NUM_LANES*2*DATA_W-1:0] res_data,
    output logic                          mem_req,
    output logic [ADDR_W-1:0]             mem_addr,
    input  logic [DATA_W-1:0]             mem_rdata
);

    localparam int RES_W = 2 * DATA_W;

    logic [NUM_LANES-1:0]        lane_en;
    logic                        skew_q;
    logic                        group_hold;
    logic [NUM_LANES-1:0]        mul_lreq, mul_gnt;
    logic [NUM_LANES-1:0]        mem_lreq, mem_gnt;
    logic [NUM_LANES*DATA_W-1:0] hold_a, hold_b;
    logic [DATA_W-1:0]           mul_a, mul_b;
    logic [RES_W-1:0]            mul_prod;

    qlg_stagger #(.NUM_LANES(NUM_LANES)) u_stagger (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .skew_mode (skew_mode),
        .lane_en   (lane_en),
        .skew_q    (skew_q)
    );

    qlg_prio_arb #(.N(NUM_LANES)) u_mul_arb (.req(mul_lreq), .gnt(mul_gnt));
    qlg_prio_arb #(.N(NUM_LANES)) u_mem_arb (.req(mem_lreq), .gnt(mem_gnt));

    assign group_hold = !skew_q && (|lane_stall);

    always_comb begin
        mul_a    = '0;
        mul_b    = '0;
        mem_addr = '0;
        for (int k = 0; k < NUM_LANES; k++) begin
            if (mul_gnt[k]) begin
                mul_a = mul_a | hold_a[k*DATA_W +: DATA_W];
                mul_b = mul_b | hold_b[k*DATA_W +: DATA_W];
            end
            if (mem_gnt[k]) mem_addr = mem_addr | hold_a[k*DATA_W +: ADDR_W];
        end
    end

    assign mul_prod = {{DATA_W{1'b0}}, mul_a} * {{DATA_W{1'b0}}, mul_b};
    assign mem_req  = |mem_gnt;

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        qlg_lane #(.DATA_W(DATA_W), .RES_W(RES_W)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .in_valid   (in_valid[k]),
            .in_op      (in_op[k*OP_W +: OP_W]),
            .in_a       (in_a[k*DATA_W +: DATA_W]),
            .in_b       (in_b[k*DATA_W +: DATA_W]),
            .enable     (lane_en[k]),
            .group_hold (group_hold),
            .mul_gnt    (mul_gnt[k]),
            .mem_gnt    (mem_gnt[k]),
            .mul_prod   (mul_prod),
            .mem_rdata  (mem_rdata),
            .in_ready   (in_ready[k]),
            .mul_req    (mul_lreq[k]),
            .mem_req    (mem_lreq[k]),
            .stall      (lane_stall[k]),
            .res_valid  (res_valid[k]),
            .res_data   (res_data[k*RES_W +: RES_W]),
            .slot_a     (hold_a[k*DATA_W +: DATA_W]),
            .slot_b     (hold_b[k*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/qlg_checker.sv
module qlg_checker #(
    parameter int NUM_LANES = 4,
    parameter int DATA_W    = 16
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_LANES-1:0]        in_ready,
    input logic [NUM_LANES-1:0]        lane_stall,
    input logic [NUM_LANES-1:0]        res_valid,
    input logic [NUM_LANES-1:0]        mul_lreq,
    input logic [NUM_LANES-1:0]        mul_gnt,
    input logic [NUM_LANES-1:0]        mem_lreq,
    input logic [NUM_LANES-1:0]        mem_gnt,
    input logic [NUM_LANES-1:0]        lane_en,
    input logic                        skew_q,
    input logic [NUM_LANES*DATA_W-1:0] hold_a,
    input logic [NUM_LANES*DATA_W-1:0] hold_b
);

    p_mul_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mul_gnt));

    p_mul_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|mul_lreq) |-> (|mul_gnt));

    p_mem_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_gnt));

    p_mem_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_lreq) |-> (|mem_gnt));

    p_stall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid & $past(lane_stall)) == '0);

    p_stall_noaccept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_stall & in_ready) == '0);

    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!skew_q && lane_stall != '0) |-> in_ready == '0);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~lane_en) == '0);

    for (genvar k = 1; k < NUM_LANES; k++) begin : g_order
        p_mul_lowest_r3: assert property (@(posedge clk) disable iff (!rst_n)
            mul_gnt[k] |-> (mul_lreq[k-1:0] == '0));

        p_skew_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (skew_q && lane_en[k]) |-> lane_en[k-1]);
    end

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_hold
        p_hold_ops_r3: assert property (@(posedge clk) disable iff (!rst_n)
            lane_stall[k] |=> ($stable(hold_a[k*DATA_W +: DATA_W]) &&
                               $stable(hold_b[k*DATA_W +: DATA_W])));
    end

endmodule

bind quad_lane_group qlg_checker #(
    .NUM_LANES (NUM_LANES),
    .DATA_W    (DATA_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .lane_stall (lane_stall),
    .res_valid  (res_valid),
    .mul_lreq   (mul_lreq),
    .mul_gnt    (mul_gnt),
    .mem_lreq   (mem_lreq),
    .mem_gnt    (mem_gnt),
    .lane_en    (lane_en),
    .skew_q     (skew_q),
    .hold_a     (hold_a),
    .hold_b     (hold_b)
);

// File: tb/tb_quad_lane_group.sv
module tb_quad_lane_group;
    import qlg_pkg::*;

    localparam int NL = 4;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int RW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch = 1'b0;
    logic skew_mode = 1'b0;

    logic [NL-1:0]    drv_valid = '0;
    logic [2:0]       drv_op [NL];
    logic [DW-1:0]    drv_a  [NL];
    logic [DW-1:0]    drv_b  [NL];

    logic [NL*3-1:0]  in_op;
    logic [NL*DW-1:0] in_a, in_b;
    logic [NL-1:0]    in_ready, lane_stall, res_valid;
    logic [NL*RW-1:0] res_data;
    logic             mem_req;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_rdata = '0;

    always_comb begin
        for (int k = 0; k < NL; k++) begin
            in_op[k*3 +: 3]   = drv_op[k];
            in_a[k*DW +: DW]  = drv_a[k];
            in_b[k*DW +: DW]  = drv_b[k];
        end
    end

    quad_lane_group #(.NUM_LANES(NL), .DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .skew_mode(skew_mode),
        .in_valid(drv_valid), .in_op(in_op), .in_a(in_a), .in_b(in_b),
        .in_ready(in_ready), .lane_stall(lane_stall), .res_valid(res_valid),
        .res_data(res_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int run_done = 0;
    int run_first = -1;
    int run_last = -1;
    int run_stall = 0;

    logic [RW-1:0] exp_q [NL][$];
    string         tag_q [NL][$];

    function automatic logic [DW-1:0] memfn(input logic [AW-1:0] ad);
        return 16'(ad) * 16'd157 + 16'd677;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rdata <= mem_req ? memfn(mem_addr) : 16'h0000;
    end

    function automatic logic [RW-1:0] expect_of(input logic [2:0] op,
                                                input logic [DW-1:0] a,
                                                input logic [DW-1:0] b);
        logic [DW-1:0] r;
        case (op)
            3'd0: r = a + b;
            3'd1: r = a - b;
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = a;
            3'd6: return {16'h0, a} * {16'h0, b};
            default: return {16'h0, memfn(a[AW-1:0])};
        endcase
        return {16'h0, r};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (lane_stall != '0) run_stall++;
            for (int k = 0; k < NL; k++) begin
                if (res_valid[k]) begin
                    run_done++;
                    if (run_first < 0) run_first = cyc;
                    run_last = cyc;
                    if (exp_q[k].size() == 0) begin
                        check(1'b0, "R1 unexpected result", res_data[k*RW +: RW], 32'h0);
                    end else begin
                        logic [RW-1:0] e;
                        string t;
                        e = exp_q[k].pop_front();
                        t = tag_q[k].pop_front();
                        check(res_data[k*RW +: RW] == e, t, res_data[k*RW +: RW], e);
                    end
                end
            end
        end
    end

    task automatic push_exp(input int k, input logic [2:0] op,
                            input logic [DW-1:0] a, input logic [DW-1:0] b,
                            input string tag);
        exp_q[k].push_back(expect_of(op, a, b));
        tag_q[k].push_back(tag);
    endtask

    // driver: called at a falling edge, returns at a falling edge
    task automatic send(input int k, input logic [2:0] op,
                        input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input string tag);
        drv_valid[k] = 1'b1;
        drv_op[k] = op;
        drv_a[k] = a;
        drv_b[k] = b;
        #1;
        while (!in_ready[k]) begin
            @(negedge clk);
            #1;
        end
        push_exp(k, op, a, b, tag);
        @(negedge clk);
        drv_valid[k] = 1'b0;
    endtask

    task automatic stream(input int k, input int iters);
        for (int i = 0; i < iters; i++) begin
            for (int j = 0; j < 3; j++)
                send(k, 3'd0, DW'(100 * k + 10 * i + j), DW'(7 + j), "R8/R9 add");
            send(k, 3'd6, DW'(300 + 17 * k + i), DW'(1000 + 3 * i), "R2 mul in stream");
        end
    endtask

    task automatic do_launch(input bit sk);
        @(negedge clk);
        skew_mode = sk;
        launch = 1'b1;
        @(negedge clk);
        launch = 1'b0;
    endtask

    task automatic clear_run();
        run_done = 0;
        run_first = -1;
        run_last = -1;
        run_stall = 0;
    endtask

    task automatic run_workload(input bit sk, output int span, output int stalls, output int done);
        clear_run();
        do_launch(sk);
        for (int k = 0; k < NL; k++) begin
            automatic int kk = k;
            fork
                stream(kk, 4);
            join_none
        end
        wait fork;
        repeat (6) @(negedge clk);
        span = run_last - run_first + 1;
        stalls = run_stall;
        done = run_done;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R9 watchdog: got %0d cycles expected completion", 20000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int span_s, stall_s, done_s, span_l, stall_l, done_l;
        for (int k = 0; k < NL; k++) begin
            drv_op[k] = 3'd0;
            drv_a[k] = '0;
            drv_b[k] = '0;
        end
        repeat (3) @(negedge clk);
        // R10: reset state
        check(in_ready == '0, "R10 in_ready in reset", 32'(in_ready), 32'h0);
        check(res_valid == '0, "R10 res_valid in reset", 32'(res_valid), 32'h0);
        check(lane_stall == '0, "R10 lane_stall in reset", 32'(lane_stall), 32'h0);
        check(mem_req == 1'b0, "R10 mem_req in reset", 32'(mem_req), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == '0, "R10 no ready before launch", 32'(in_ready), 32'h0);

        // R6: skewed opening order
        do_launch(1'b1);
        #1 check(in_ready == 4'b0001, "R6 skew step 0", 32'(in_ready), 32'h1);
        @(negedge clk); #1 check(in_ready == 4'b0011, "R6 skew step 1", 32'(in_ready), 32'h3);
        @(negedge clk); #1 check(in_ready == 4'b0111, "R6 skew step 2", 32'(in_ready), 32'h7);
        @(negedge clk); #1 check(in_ready == 4'b1111, "R6 skew step 3", 32'(in_ready), 32'hF);
        do_launch(1'b0);
        #1 check(in_ready == 4'b1111, "R6 lockstep opens all", 32'(in_ready), 32'hF);

        // R1: ALU latency
        @(negedge clk);
        drv_valid[0] = 1'b1; drv_op[0] = 3'd0; drv_a[0] = 16'h1234; drv_b[0] = 16'h0F0F;
        #1 check(in_ready[0], "R1 lane0 ready", 32'(in_ready[0]), 32'h1);
        push_exp(0, 3'd0, 16'h1234, 16'h0F0F, "R1 add data");
        @(negedge clk);
        drv_valid[0] = 1'b0;
        #1 check(res_valid == 4'b0000, "R1 no result one cycle after accept", 32'(res_valid), 32'h0);
        @(negedge clk);
        #1 check(res_valid == 4'b0001, "R1 result two edges after accept", 32'(res_valid), 32'h1);

        // R1: every ALU op on every lane
        for (int op = 1; op <= 5; op++) begin
            for (int k = 0; k < NL; k++) begin
                automatic int kk = k;
                automatic int oo = op;
                fork
                    send(kk, 3'(oo), DW'(3 + kk * 16'h1111), DW'(5 + oo * 16'h0F01), "R1 alu op");
                join_none
            end
            wait fork;
        end
        repeat (3) @(negedge clk);

        // R3/R5/R7/R2: four multiplies collide in lockstep
        drv_op[0] = 3'd6; drv_a[0] = 16'hFFFF; drv_b[0] = 16'hFFFF;
        drv_op[1] = 3'd6; drv_a[1] = 16'h1234; drv_b[1] = 16'h5678;
        drv_op[2] = 3'd6; drv_a[2] = 16'h8000; drv_b[2] = 16'h0002;
        drv_op[3] = 3'd6; drv_a[3] = 16'h00FF; drv_b[3] = 16'h0101;
        drv_valid = 4'b1111;
        #1 check(in_ready == 4'b1111, "R7 all ready before multiplies", 32'(in_ready), 32'hF);
        for (int k = 0; k < NL; k++) push_exp(k, 3'd6, drv_a[k], drv_b[k], "R2 product");
        @(negedge clk);
        drv_valid = '0;
        #1 check(lane_stall == 4'b1110, "R3 lowest lane wins multiplier", 32'(lane_stall), 32'hE);
        check(in_ready == 4'b0000, "R5/R7 no accept while stalled", 32'(in_ready), 32'h0);
        @(negedge clk);
        #1 check(res_valid == 4'b0001, "R2 lane0 product after grant", 32'(res_valid), 32'h1);
        check(lane_stall == 4'b1100, "R3 second grant to lane1", 32'(lane_stall), 32'hC);
        @(negedge clk);
        #1 check(res_valid == 4'b0010, "R5 stalled lanes quiet", 32'(res_valid), 32'h2);
        check(lane_stall == 4'b1000, "R3 third grant to lane2", 32'(lane_stall), 32'h8);
        @(negedge clk);
        #1 check(res_valid == 4'b0100, "R3 lane2 result", 32'(res_valid), 32'h4);
        check(lane_stall == 4'b0000, "R3 lane3 granted", 32'(lane_stall), 32'h0);
        @(negedge clk);
        #1 check(res_valid == 4'b1000, "R3 lane3 result last", 32'(res_valid), 32'h8);

        // R4/R11: multiply and two loads in one cycle
        @(negedge clk);
        drv_op[0] = 3'd6; drv_a[0] = 16'h0007; drv_b[0] = 16'h0009;
        drv_op[1] = 3'd7; drv_a[1] = 16'hAB11; drv_b[1] = 16'h0000;
        drv_op[2] = 3'd7; drv_a[2] = 16'h0022; drv_b[2] = 16'h0000;
        drv_op[3] = 3'd0; drv_a[3] = 16'h0001; drv_b[3] = 16'h0002;
        drv_valid = 4'b1111;
        #1 check(in_ready == 4'b1111, "R4 all ready before loads", 32'(in_ready), 32'hF);
        for (int k = 0; k < NL; k++) push_exp(k, drv_op[k], drv_a[k], drv_b[k], "R4 load/mul data");
        @(negedge clk);
        drv_valid = '0;
        #1 check(lane_stall == 4'b0100, "R11 mul and load proceed, lane2 waits", 32'(lane_stall), 32'h4);
        check(mem_req == 1'b1, "R4 request in grant cycle", 32'(mem_req), 32'h1);
        check(mem_addr == 8'h11, "R4 address of lane1", 32'(mem_addr), 32'h11);
        @(negedge clk);
        #1 check(res_valid == 4'b1011, "R11 three results together", 32'(res_valid), 32'hB);
        check(mem_addr == 8'h22, "R4 address of lane2", 32'(mem_addr), 32'h22);
        @(negedge clk);
        #1 check(res_valid == 4'b0100, "R4 lane2 load result", 32'(res_valid), 32'h4);
        check(mem_req == 1'b0, "R4 port idle", 32'(mem_req), 32'h0);
        repeat (2) @(negedge clk);

        // R8/R9: workload in both modes
        run_workload(1'b1, span_s, stall_s, done_s);
        check(stall_s == 0, "R8 no stall in skewed mode", 32'(stall_s), 32'h0);
        check(span_s == 19, "R8 skewed span", 32'(span_s), 32'd19);
        check(done_s == 64, "R8 skewed completions", 32'(done_s), 32'd64);
        run_workload(1'b0, span_l, stall_l, done_l);
        check(stall_l > 0, "R7 lockstep stalls on multiplier", 32'(stall_l), 32'h1);
        check(done_l == 64, "R9 lockstep completions", 32'(done_l), 32'd64);
        check(span_l > span_s, "R9 lockstep slower per cycle", 32'(span_l), 32'(span_s + 1));
        $display("skewed: %0d ops / %0d cycles, lockstep: %0d ops / %0d cycles",
                 done_s, span_s, done_l, span_l);

        begin
            int left;
            left = 0;
            for (int k = 0; k < NL; k++) left += exp_q[k].size();
            check(left == 0, "R1 every issued op returned", 32'(left), 32'h0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule